// File: doc/BRIEF.md
# Host-Programmed Serial Flash Command Engine

This block drives one serial-flash command at a time for a host that works through a byte-wide register bus. The host first writes an opcode, three address bytes and one extra data byte into separate registers. It then writes a control byte that starts the transfer. The control byte selects the clock rate, the outgoing frame shape and the number of response bytes to collect. The engine then lowers chip select and shifts the chosen bytes out in SPI mode 0. It clocks in up to three response bytes and releases chip select after a short tail.

The outgoing frame always begins with the opcode. A 2-bit length code chooses one of four frames of 1, 2, 4 or 5 bytes. The address bytes sit in separate registers, but they always leave the engine most significant first, straight after the opcode. The host polls bit 7 of the control register until it clears, then reads the captured bytes from three consecutive offsets.

The register bus has a one-cycle read latency: `bus_rdata` shows the register at `bus_addr` as it stood at the previous clock edge. The clock ratios are set by parameters.

Top module: `spi_cmd_engine`

## Requirements
- R1: After a synchronous reset, chip select is high, SCK and MOSI are low, and the busy flag is clear. Every readable register (offsets 0 to 7) reads 0.
- R2: A write to offset 0 starts a transfer only when data bits 7:5 are 3'b010. Bit 4 then selects the fast clock (1) or the slow clock (0). Any other value in bits 7:5 starts nothing and changes nothing.
- R3: Offset 0 reads back as {busy, 2'b00, fast, read count[1:0], length code[1:0]}. The low fields hold the last accepted start. Busy is 1 from the start edge until chip select is released.
- R4: Control bits 1:0 give the length code, and the frame always starts with the opcode from offset 1. Code 0 sends the opcode only. Code 1 adds the data byte from offset 7. Code 2 adds the three address bytes. Code 3 adds the address bytes and then the data byte.
- R5: The address bytes go out most significant first: offset 4 (bits 23:16), then offset 3, then offset 2 (bits 7:0). Every byte is sent MSB first.
- R6: Control bits 3:2 give a read count of 0 to 3. That many bytes are clocked in after the write phase, with MOSI held low. The first byte read back at offset 5, the second at 6 and the third at 7. Response slots that were not filled read as 0.
- R7: The interface uses SPI mode 0. SCK idles low. MOSI changes only while SCK falls, never while SCK is high. MISO is sampled as SCK rises.
- R8: One SCK half-period lasts FAST_HALF clock cycles at the fast rate and SLOW_HALF cycles at the slow rate.
- R9: Chip select stays low for the whole write and read phase, and SCK pulses only while it is low. It rises one full SCK period after the last falling SCK edge.
- R10: A write to offset 0 while busy is ignored. The running transfer is unchanged, no second transfer follows, and the readback fields are unchanged.
- R11: Offsets 1 to 4 read back the opcode and address bytes as written. Offset 7 is write-only for the data byte and reads the third response byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset presented on the previous cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench runs all 32 combinations of clock rate, length code and read count. Each combination uses register contents and response bytes derived from its own indices, so a byte that is swapped, dropped or read from the wrong register shows up as a wrong bit.

The bench counts SCK edges to check the frame lengths. It also times the SCK half-period and the chip-select tail, which confirms that each rate and each frame length is decoded separately.

Further cases cover control values with a bad upper field and a restart attempt in the middle of a transfer. They show that neither starts a frame nor alters the readback fields.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W       = 8;
  localparam int TX_MAX_BYTES = 5;
  localparam int RX_MAX_BYTES = 3;
  localparam int FRAME_W      = TX_MAX_BYTES * BYTE_W;
  localparam int BITCNT_W     = $clog2((TX_MAX_BYTES + RX_MAX_BYTES) * BYTE_W + 1);

  localparam logic [2:0] START_KEY = 3'b010;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} xfer_state_t;

  function automatic logic [2:0] tx_byte_count(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic [BYTE_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic [RX_MAX_BYTES*BYTE_W-1:0] rx_flat,
  output logic [BYTE_W-1:0]    opcode_q,
  output logic [BYTE_W-1:0]    addr_hi_q,
  output logic [BYTE_W-1:0]    addr_mid_q,
  output logic [BYTE_W-1:0]    addr_lo_q,
  output logic [BYTE_W-1:0]    data_q,
  output logic [4:0]           cfg_q,
  output logic                 start
);
  logic ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == 3'd0);
  assign start   = ctrl_wr && !busy && (bus_wdata[7:5] == START_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q   <= '0;
      addr_hi_q  <= '0;
      addr_mid_q <= '0;
      addr_lo_q  <= '0;
      data_q     <= '0;
      cfg_q      <= '0;
    end else begin
      if (start) cfg_q <= bus_wdata[4:0];
      if (bus_wr) begin
        case (bus_addr)
          3'd1: opcode_q   <= bus_wdata;
          3'd2: addr_lo_q  <= bus_wdata;
          3'd3: addr_mid_q <= bus_wdata;
          3'd4: addr_hi_q  <= bus_wdata;
          3'd7: data_q     <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        3'd0: bus_rdata <= {busy, 2'b00, cfg_q};
        3'd1: bus_rdata <= opcode_q;
        3'd2: bus_rdata <= addr_lo_q;
        3'd3: bus_rdata <= addr_mid_q;
        3'd4: bus_rdata <= addr_hi_q;
        3'd5: bus_rdata <= rx_flat[BYTE_W-1:0];
        3'd6: bus_rdata <= rx_flat[2*BYTE_W-1:BYTE_W];
        default: bus_rdata <= rx_flat[3*BYTE_W-1:2*BYTE_W];
      endcase
    end
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int CW = $clog2(SLOW_HALF + 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_HALF - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = fast ? FAST_LAST : SLOW_LAST;
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [4:0]        start_cfg,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] addr_hi,
  input  logic [BYTE_W-1:0] addr_mid,
  input  logic [BYTE_W-1:0] addr_lo,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              tick,
  input  logic              spi_miso,
  output logic              busy,
  output logic              fast_q,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic [RX_MAX_BYTES*BYTE_W-1:0] rx_flat
);
  xfer_state_t          state_q;
  logic [FRAME_W-1:0]   sreg_q;
  logic [FRAME_W-1:0]   load_frame;
  logic [BITCNT_W-1:0]  bit_cnt_q, tx_bits_q, tot_bits_q;
  logic [BITCNT_W-1:0]  tx_bits_n, tot_bits_n, rx_pos;
  logic                 tail_q;
  logic [BYTE_W-1:0]    rx_q [RX_MAX_BYTES];

  always_comb begin
    case (start_cfg[1:0])
      2'd0:    load_frame = {opcode, 32'd0};
      2'd1:    load_frame = {opcode, data_byte, 24'd0};
      2'd2:    load_frame = {opcode, addr_hi, addr_mid, addr_lo, 8'd0};
      default: load_frame = {opcode, addr_hi, addr_mid, addr_lo, data_byte};
    endcase
    tx_bits_n  = BITCNT_W'({tx_byte_count(start_cfg[1:0]), 3'b000});
    tot_bits_n = tx_bits_n + BITCNT_W'({start_cfg[3:2], 3'b000});
    rx_pos     = (bit_cnt_q - tx_bits_q) >> 3;
  end

  assign busy = (state_q != ST_IDLE);

  for (genvar g = 0; g < RX_MAX_BYTES; g++) begin : g_rx_out
    assign rx_flat[g*BYTE_W +: BYTE_W] = rx_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sreg_q     <= '0;
      bit_cnt_q  <= '0;
      tx_bits_q  <= '0;
      tot_bits_q <= '0;
      tail_q     <= 1'b0;
      fast_q     <= 1'b0;
      spi_sck    <= 1'b0;
      spi_cs_n   <= 1'b1;
      spi_mosi   <= 1'b0;
      for (int k = 0; k < RX_MAX_BYTES; k++) rx_q[k] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q    <= ST_SHIFT;
          sreg_q     <= load_frame;
          bit_cnt_q  <= '0;
          tx_bits_q  <= tx_bits_n;
          tot_bits_q <= tot_bits_n;
          fast_q     <= start_cfg[4];
          spi_cs_n   <= 1'b0;
          spi_mosi   <= load_frame[FRAME_W-1];
          for (int k = 0; k < RX_MAX_BYTES; k++) rx_q[k] <= '0;
        end
        ST_SHIFT: if (tick) begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            if (bit_cnt_q >= tx_bits_q) begin
              for (int k = 0; k < RX_MAX_BYTES; k++)
                if (rx_pos == BITCNT_W'(k)) rx_q[k] <= {rx_q[k][BYTE_W-2:0], spi_miso};
            end
          end else begin
            spi_sck <= 1'b0;
            if (bit_cnt_q == tot_bits_q - 1'b1) begin
              state_q  <= ST_TAIL;
              tail_q   <= 1'b0;
              spi_mosi <= 1'b0;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
              sreg_q    <= sreg_q << 1;
              spi_mosi  <= (bit_cnt_q + 1'b1 < tx_bits_q) ? sreg_q[FRAME_W-2] : 1'b0;
            end
          end
        end
        default: if (tick) begin
          if (tail_q) begin
            spi_cs_n <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            tail_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [BYTE_W-1:0] opcode_q, addr_hi_q, addr_mid_q, addr_lo_q, data_q;
  logic [4:0]        cfg_q;
  logic              start, busy, fast_q, tick;
  logic [RX_MAX_BYTES*BYTE_W-1:0] rx_flat;

  spi_cmd_regs regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rx_flat(rx_flat), .opcode_q(opcode_q), .addr_hi_q(addr_hi_q),
    .addr_mid_q(addr_mid_q), .addr_lo_q(addr_lo_q), .data_q(data_q),
    .cfg_q(cfg_q), .start(start)
  );

  spi_half_tick #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) tick_i (
    .clk(clk), .rst(rst), .run(busy), .fast(fast_q), .tick(tick)
  );

  spi_cmd_shifter shift_i (
    .clk(clk), .rst(rst), .start(start), .start_cfg(bus_wdata[4:0]),
    .opcode(opcode_q), .addr_hi(addr_hi_q), .addr_mid(addr_mid_q),
    .addr_lo(addr_lo_q), .data_byte(data_q), .tick(tick),
    .spi_miso(spi_miso), .busy(busy), .fast_q(fast_q), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .rx_flat(rx_flat)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       busy,
  input logic [4:0] cfg,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spi_cs_n && !spi_sck)); // R1

  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n); // R9

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R7

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0 && !busy && bus_wdata[7:5] == 3'b010) |=> busy); // R2

  AST_BAD_KEY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0 && !busy && bus_wdata[7:5] != 3'b010) |=> !busy); // R2

  AST_BUSY_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg)); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .busy(busy), .cfg(cfg_q), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  localparam int FAST_HALF = 2;
  localparam int SLOW_HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cmd_engine #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash-side model
  int cyc = 0;
  int rises = 0, cs_falls = 0;
  int t_r0 = 0, t_r1 = 0, t_fall = 0, t_csr = 0;
  int txb = 8;
  logic [63:0] mosi_cap = '0;
  logic [7:0]  resp [3];

  function automatic logic slave_bit(input int i);
    int j;
    if (i < txb) return 1'b0;
    j = i - txb;
    if (j >= 24) return 1'b0;
    return resp[j/8][7 - (j%8)];
  endfunction

  always @(posedge clk) cyc = cyc + 1;
  always @(negedge spi_cs_n) begin
    rises = 0; mosi_cap = '0; cs_falls++; spi_miso = slave_bit(0);
  end
  always @(posedge spi_sck) begin
    mosi_cap = {mosi_cap[62:0], spi_mosi};
    if (rises == 0) t_r0 = cyc;
    if (rises == 1) t_r1 = cyc;
    rises++;
  end
  always @(negedge spi_sck) begin
    t_fall = cyc; spi_miso = slave_bit(rises);
  end
  always @(posedge spi_cs_n) t_csr = cyc;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int n = 0; n < 4000; n++) begin
      rd(3'd0, v);
      if (!v[7]) return;
    end
  endtask

  function automatic int nbytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
  endfunction

  task automatic run_xfer(input int fast, input int code, input int rcnt);
    logic [7:0] op, ah, am, al, db, v;
    logic [39:0] exp_tx;
    logic [63:0] got;
    int half, tot;
    op = 8'h90 ^ 8'(fast*16 + code*4 + rcnt);
    ah = 8'hC3 + 8'(code*7 + rcnt);
    am = 8'h5A ^ 8'(rcnt*33 + fast);
    al = 8'h1E + 8'(code*19);
    db = 8'hE7 ^ 8'(rcnt*5 + code);
    for (int k = 0; k < 3; k++) resp[k] = 8'h2B * 8'(k + 1) ^ 8'(code*16 + rcnt + fast*64);
    wr(3'd1, op); wr(3'd4, ah); wr(3'd3, am); wr(3'd2, al); wr(3'd7, db);
    txb = nbytes(code) * 8;
    tot = txb + rcnt*8;
    half = fast ? FAST_HALF : SLOW_HALF;
    case (code)
      0: exp_tx = {32'd0, op};
      1: exp_tx = {24'd0, op, db};
      2: exp_tx = {8'd0, op, ah, am, al};
      default: exp_tx = {op, ah, am, al, db};
    endcase
    wr(3'd0, {3'b010, 1'(fast), 2'(rcnt), 2'(code)});
    rd(3'd0, v);
    chk(v == {1'b1, 2'b00, 1'(fast), 2'(rcnt), 2'(code)}, "R3 busy+cfg readback", v,
        {1'b1, 2'b00, 1'(fast), 2'(rcnt), 2'(code)});
    wait_idle();
    chk(rises == tot, "R4/R6 SCK edge count", rises, tot);
    got = mosi_cap >> (rcnt*8);
    chk(got[39:0] == exp_tx, "R4/R5 MOSI frame", got[39:0], exp_tx);
    chk((mosi_cap & ((64'd1 << (rcnt*8)) - 64'd1)) == 0, "R6 MOSI low in read phase", mosi_cap, 0);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] e;
      e = (k < rcnt) ? resp[k] : 8'h00;
      rd(3'(5 + k), v);
      chk(v == e, "R6/R11 response byte", v, e);
    end
    chk(t_r1 - t_r0 == 2*half, "R8 SCK period", t_r1 - t_r0, 2*half);
    chk(t_csr - t_fall == 2*half, "R9 CS tail", t_csr - t_fall, 2*half);
    rd(3'd0, v);
    chk(v == {3'b000, 1'(fast), 2'(rcnt), 2'(code)}, "R3 idle readback", v,
        {3'b000, 1'(fast), 2'(rcnt), 2'(code)});
  endtask

  initial begin
    logic [7:0] v;
    int falls0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 pins after reset",
        {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 register reset", v, 0);
    end
    // R11 readback of opcode/address registers
    wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'h69); wr(3'd4, 8'hF0);
    rd(3'd1, v); chk(v == 8'hA5, "R11 offset1", v, 8'hA5);
    rd(3'd2, v); chk(v == 8'h3C, "R11 offset2", v, 8'h3C);
    rd(3'd3, v); chk(v == 8'h69, "R11 offset3", v, 8'h69);
    rd(3'd4, v); chk(v == 8'hF0, "R11 offset4", v, 8'hF0);
    // R2 bad keys start nothing
    falls0 = cs_falls;
    foreach (bad_vals[i]) ;
    wr(3'd0, 8'h3F); wr(3'd0, 8'h6E); wr(3'd0, 8'hDB); wr(3'd0, 8'h00);
    repeat (20) @(negedge clk);
    rd(3'd0, v);
    chk(v == 8'h00, "R2 bad key ignored", v, 0);
    chk(cs_falls == falls0, "R2 no CS activity", cs_falls - falls0, 0);
    // full sweep R4 R5 R6 R8 R9
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          run_xfer(f, c, r);
    // R10 control write while busy
    falls0 = cs_falls;
    txb = 8;
    wr(3'd0, 8'h40);
    wr(3'd0, 8'h5F);
    rd(3'd0, v);
    chk(v == 8'h80, "R10 cfg held while busy", v, 8'h80);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(rises == 8, "R10 running frame unchanged", rises, 8);
    chk(cs_falls - falls0 == 1, "R10 no second transfer", cs_falls - falls0, 1);
    rd(3'd0, v);
    chk(v == 8'h00, "R10 readback after", v, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] bad_vals [1];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule